// File: doc/BRIEF.md
# System Reset Merger with Cause Register

This block combines two reset requests into one system reset for the rest of the chip. The first is an active-low reset pin. The second is a one-cycle overflow pulse from a watchdog counter that sits outside the block. The pin reset takes effect at once, without waiting for a clock. Its release is synchronized to the clock. A watchdog overflow may turn into a reset, and that reset is held for a fixed count of clocks.

The block holds one 8-bit control/status register. It has an overflow flag in bit 7 and a watchdog-reset enable in bit 6, and bits 5:0 read as the constant 0x1F. Only the pin reset puts this register back to its reset value. A watchdog reset leaves it alone. After any reset, firmware reads the flag: 1 means the watchdog caused the reset, and 0 (with the register at 0x1F) means the pin did. A single-cycle write strobe updates the register. The read data is always valid.

Top module: `rstctl_top`

## Requirements
- R1: While `pin_rst_n` is low, `sys_rst` is 1 at once, without any clock edge.
- R2: After `pin_rst_n` rises, `sys_rst` stays 1 through the first rising clock edge and falls at the second. This also holds when a watchdog stretch was running when the pin was asserted, because the pin reset cancels the stretch.
- R3: A pin reset sets the register to 0x1F, so bit 7 (flag) is 0 and bit 6 (enable) is 0.
- R4: When bit 6 is 1 and `wdt_ovf` is sampled high while no stretch is running, `sys_rst` goes to 1 after that clock edge and stays 1 for exactly 518 clock cycles.
- R5: A `wdt_ovf` pulse that arrives while a stretch is running neither restarts nor lengthens the stretch.
- R6: Every sampled `wdt_ovf` sets bit 7. When bit 6 is 0, the pulse does nothing else and `sys_rst` stays 0.
- R7: A watchdog-caused reset does not change the register. After a stretch, the register reads 0xDF (flag 1, enable 1).
- R8: A write with bit 7 = 0 clears the flag, and a write with bit 7 = 1 leaves it unchanged. Bit 6 takes the value written. Writes made while `sys_rst` is 1 are ignored.
- R9: If an overflow and a write that clears the flag happen in the same cycle, the flag ends up set.
- R10: Bits 5:0 always read 0x1F, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pin_rst_n | input | 1 | Asynchronous active-low reset pin |
| wdt_ovf | input | 1 | Watchdog overflow pulse, one cycle wide |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register contents |
| sys_rst | output | 1 | Merged active-high system reset |

## Verification
A stretch counter that is wrong by even one count shows up as a `sys_rst` pulse of 517 or 519 cycles. The bench and the checker both see this at the edge where the pulse ends. If the register is wrongly cleared by the internal reset, the read-back right after the stretch shows 0x1F instead of 0xDF, so the reset cause is lost. A synchronizer with the wrong depth moves the falling edge of `sys_rst` by a whole cycle after the pin is released. A stuck enable or a flag with the wrong priority appears on `reg_rdata` one cycle after the overflow or the write that caused it.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
   localparam int unsigned CSR_W    = 8;
   localparam int unsigned FLAG_POS = 7;
   localparam int unsigned EN_POS   = 6;
   localparam int unsigned FIX_W    = 6;
   localparam logic [FIX_W-1:0] FIX_VAL = 6'h1F;

   typedef struct packed {
      logic flag;
      logic en;
   } csr_ctl_t;

   localparam csr_ctl_t CTL_RESET = '{flag: 1'b0, en: 1'b0};
endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic pin_rst_n,
   output logic rst_sync_n
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rstctl_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge pin_rst_n) begin
            if (!pin_rst_n) chain[0] <= 1'b0;
            else            chain[0] <= 1'b1;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge pin_rst_n) begin
            if (!pin_rst_n) chain[i] <= 1'b0;
            else            chain[i] <= chain[i-1];
         end
      end
   end

   assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/rstctl_stretch.sv
module rstctl_stretch #(
   parameter int unsigned STRETCH_CYCLES = 518
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic active
);
   localparam int unsigned CNT_W = (STRETCH_CYCLES > 2) ? $clog2(STRETCH_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STRETCH_CYCLES - 1);

   if (STRETCH_CYCLES < 2) begin : g_bad_len
      $error("rstctl_stretch: STRETCH_CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         remain <= '0;
      end else if (active) begin
         if (remain == '0) active <= 1'b0;
         else              remain <= remain - 1'b1;
      end else if (trig) begin
         active <= 1'b1;
         remain <= LOAD_VAL;
      end
   end
endmodule

// File: rtl/rstctl_csr.sv
module rstctl_csr
   import rstctl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ovf,
   input  logic             wr_ok,
   input  logic [CSR_W-1:0] wdata,
   output csr_ctl_t         ctl,
   output logic [CSR_W-1:0] rdata
);
   csr_ctl_t ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= CTL_RESET;
      end else begin
         if (ovf)                         ctl_q.flag <= 1'b1;
         else if (wr_ok && !wdata[FLAG_POS]) ctl_q.flag <= 1'b0;
         if (wr_ok)                       ctl_q.en   <= wdata[EN_POS];
      end
   end

   assign ctl   = ctl_q;
   assign rdata = {ctl_q.flag, ctl_q.en, FIX_VAL};
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
   import rstctl_pkg::*;
#(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned STRETCH_CYCLES = 518
) (
   input  logic             clk,
   input  logic             pin_rst_n,
   input  logic             wdt_ovf,
   input  logic             reg_wr,
   input  logic [CSR_W-1:0] reg_wdata,
   output logic [CSR_W-1:0] reg_rdata,
   output logic             sys_rst
);
   logic     rst_sync_n;
   logic     wd_active;
   logic     wd_trig;
   logic     wr_ok;
   csr_ctl_t ctl;

   rstctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .pin_rst_n  (pin_rst_n),
      .rst_sync_n (rst_sync_n)
   );

   assign wd_trig = wdt_ovf && ctl.en;

   rstctl_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_stretch (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .trig   (wd_trig),
      .active (wd_active)
   );

   assign sys_rst = !rst_sync_n || wd_active;
   assign wr_ok   = reg_wr && !sys_rst;

   rstctl_csr u_csr (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .ovf   (wdt_ovf),
      .wr_ok (wr_ok),
      .wdata (reg_wdata),
      .ctl   (ctl),
      .rdata (reg_rdata)
   );
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk #(
   parameter int unsigned STRETCH_CYCLES = 518
) (
   input logic       clk,
   input logic       pin_rst_n,
   input logic       wdt_ovf,
   input logic [7:0] reg_rdata,
   input logic       sys_rst,
   input logic       rst_sync_n,
   input logic       wd_active
);
   logic [31:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)    hi_cnt <= '0;
      else if (wd_active) hi_cnt <= hi_cnt + 1;
      else                hi_cnt <= '0;
   end

   AST_PIN_FORCES_RST: assert property (@(posedge clk) !pin_rst_n |-> sys_rst); // R1

   AST_STRETCH_START: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (wdt_ovf && reg_rdata[6] && !sys_rst) |=> sys_rst); // R4

   AST_STRETCH_LEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $fell(wd_active) |-> hi_cnt == STRETCH_CYCLES); // R4

   AST_NO_RST_DISABLED: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (wdt_ovf && !reg_rdata[6] && !sys_rst) |=> !sys_rst); // R6

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
      wdt_ovf |=> reg_rdata[7]); // R6

   AST_KEEP_CSR: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $fell(wd_active) |-> reg_rdata[7:6] == 2'b11); // R7

   AST_NO_WRITE_IN_RST: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (wd_active && !wdt_ovf) |=> $stable(reg_rdata)); // R8
endmodule

bind rstctl_top rstctl_chk #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_chk (
   .clk        (clk),
   .pin_rst_n  (pin_rst_n),
   .wdt_ovf    (wdt_ovf),
   .reg_rdata  (reg_rdata),
   .sys_rst    (sys_rst),
   .rst_sync_n (rst_sync_n),
   .wd_active  (wd_active)
);

// File: tb/sim_rstctl_top.sv
module sim_rstctl_top;
   localparam int CLK_PERIOD = 10;
   localparam int STRETCH    = 518;

   logic       clk = 1'b0;
   logic       pin_rst_n = 1'b0;
   logic       wdt_ovf = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       sys_rst;

   int total = 0;
   int bad   = 0;

   rstctl_top u0 (
      .clk       (clk),
      .pin_rst_n (pin_rst_n),
      .wdt_ovf   (wdt_ovf),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .sys_rst   (sys_rst)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic pulse_ovf();
      @(negedge clk);
      wdt_ovf = 1'b1;
      @(negedge clk);
      wdt_ovf = 1'b0;
   endtask

   task automatic t_pin_reset();
      @(negedge clk);
      pin_rst_n = 1'b0;
      #1;
      chk(sys_rst == 1'b1, "R1", sys_rst, 1);
      repeat (3) @(negedge clk);
      chk(reg_rdata == 8'h1F, "R3", reg_rdata, 8'h1F);
      pin_rst_n = 1'b1;
      @(negedge clk);
      chk(sys_rst == 1'b1, "R2", sys_rst, 1);
      @(negedge clk);
      chk(sys_rst == 1'b0, "R2", sys_rst, 0);
      chk(reg_rdata == 8'h1F, "R3", reg_rdata, 8'h1F);
   endtask

   task automatic t_disabled_ovf();
      pulse_ovf();
      chk(sys_rst == 1'b0, "R6", sys_rst, 0);
      chk(reg_rdata == 8'h9F, "R6", reg_rdata, 8'h9F);
      repeat (5) @(negedge clk);
      chk(sys_rst == 1'b0, "R6", sys_rst, 0);
   endtask

   task automatic t_writes();
      wr_reg(8'h00);
      chk(reg_rdata == 8'h1F, "R8", reg_rdata, 8'h1F);
      wr_reg(8'hFF);
      chk(reg_rdata == 8'h5F, "R8", reg_rdata, 8'h5F);
      wr_reg(8'h20);
      chk(reg_rdata == 8'h1F, "R10", reg_rdata, 8'h1F);
   endtask

   task automatic t_set_wins();
      pulse_ovf();
      @(negedge clk);
      reg_wr = 1'b1; reg_wdata = 8'h00; wdt_ovf = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; wdt_ovf = 1'b0;
      chk(reg_rdata == 8'h9F, "R9", reg_rdata, 8'h9F);
      wr_reg(8'h00);
   endtask

   task automatic t_stretch();
      int hi = 0;
      wr_reg(8'h40);
      chk(reg_rdata == 8'h5F, "R8", reg_rdata, 8'h5F);
      pulse_ovf();
      for (int k = 0; k < 2000; k++) begin
         if (!sys_rst) break;
         hi++;
         reg_wr = (hi == 100);
         reg_wdata = 8'h00;
         wdt_ovf = (hi == 300);
         @(negedge clk);
      end
      reg_wr = 1'b0; wdt_ovf = 1'b0;
      chk(hi == STRETCH, "R4", hi, STRETCH);
      chk(hi == STRETCH, "R5", hi, STRETCH);
      chk(reg_rdata == 8'hDF, "R7", reg_rdata, 8'hDF);
      repeat (3) @(negedge clk);
      chk(sys_rst == 1'b0, "R5", sys_rst, 0);
   endtask

   task automatic t_pin_in_stretch();
      chk(reg_rdata[6] == 1'b1, "R4", reg_rdata[6], 1);
      pulse_ovf();
      chk(sys_rst == 1'b1, "R4", sys_rst, 1);
      repeat (50) @(negedge clk);
      pin_rst_n = 1'b0;
      @(negedge clk);
      pin_rst_n = 1'b1;
      @(negedge clk);
      chk(sys_rst == 1'b1, "R2", sys_rst, 1);
      @(negedge clk);
      chk(sys_rst == 1'b0, "R2", sys_rst, 0);
      chk(reg_rdata == 8'h1F, "R3", reg_rdata, 8'h1F);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2;
      chk(sys_rst == 1'b1, "R1", sys_rst, 1);
      chk(reg_rdata == 8'h1F, "R3", reg_rdata, 8'h1F);
      repeat (3) @(negedge clk);
      pin_rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(sys_rst == 1'b0, "R2", sys_rst, 0);
      t_disabled_ovf();
      t_writes();
      t_set_wins();
      t_stretch();
      t_pin_in_stretch();
      t_pin_reset();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule